// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register file of a processor core that runs in several privilege and exception modes. Each port addresses a 4-bit architectural register index. The block combines that index with the current mode to choose one physical storage slot. The low registers are common to every mode. Some upper registers are private to particular modes, so a mode change alters which copies are visible without moving any data.

The file has two combinational read ports and one write port that writes on the clock edge. It holds 30 physical slots. The fast-interrupt mode has private copies of indices 8 to 12, and every exception mode has private copies of index 13 (stack pointer) and index 14 (link register). Index 15 is not stored here: it reads as zero, and writes to it are dropped. A read of the slot being written in the same cycle returns the incoming data.

Top module: `mode_banked_regfile`

## Requirements
- R1: Indices 0 to 7 select the same physical register in every mode, so a value written in one mode reads back unchanged in any other mode.
- R2: Indices 8 to 12 select a private set while the mode code is 1 (fast interrupt). Every other mode code shares a single common set for these indices.
- R3: Indices 13 and 14 select a private pair for each of the mode codes 1 to 5. Mode code 0 (user/system) has its own pair. A write to index 13 or 14 in one of these modes is invisible from the others.
- R4: The mode input is 3 bits: 0 user/system, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. Codes 6 and 7 select exactly the registers that code 0 selects.
- R5: A write takes effect on the rising clock edge when wr_en is 1, using the mode present in that same cycle. With wr_en at 0 no register changes.
- R6: Both read ports are combinational and independent, and they can return two different registers in the same cycle.
- R7: When a read port addresses the physical slot that is being written in the current cycle, it returns wr_data in that cycle.
- R8: An active-low asynchronous reset clears all 30 physical registers to zero.
- R9: Index 15 always reads as zero on both ports, including during a same-cycle write to index 15. A write to index 15 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current operating mode code |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | DATA_W | Write data |

## Verification
The main function is exercised by writing and reading one index across several modes. Shared indices show a value appearing in every mode. The fast-interrupt set for 8 to 12 shows that only mode 1 sees a different copy. Indices 13 and 14 written in each exception mode show whether copies are private per mode or leak into user mode. Unused mode codes 6 and 7 are checked against user-mode contents, which tells correct aliasing apart from a mapping to some other bank. Further cycles cover:
- same-cycle write and read on each port (bypass, compared with the value before the edge),
- a mode change in the cycle after a write,
- writes and reads at index 15,
- a reset applied in the middle of a run.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } mode_e;

  localparam int IDX_W        = 4;
  localparam int MODE_W       = 3;
  localparam int N_SHARED     = 8;   // indices 0..7
  localparam int FIQ_FIRST    = 8;   // first fast-interrupt banked index
  localparam int FIQ_LAST     = 12;  // last fast-interrupt banked index
  localparam int N_FIQ_BANK   = FIQ_LAST - FIQ_FIRST + 1;
  localparam int SP_IDX       = 13;
  localparam int LR_IDX       = 14;
  localparam int N_EXC_MODES  = 5;
  localparam int N_PER_EXC    = 2;
  localparam int N_USER_HIGH  = LR_IDX - FIQ_FIRST + 1;
  localparam int FIQ_BASE     = N_SHARED + N_USER_HIGH;
  localparam int EXC_BASE     = FIQ_BASE + N_FIQ_BANK;
  localparam int N_SLOTS      = EXC_BASE + N_EXC_MODES * N_PER_EXC;
  localparam int SLOT_W       = $clog2(N_SLOTS);
  localparam int N_PORTS      = 3;  // two reads, one write

  // Position of an exception mode within the exception banks, and whether it is one.
  function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(MODE_FIQ)) && (m <= MODE_W'(MODE_UND));
  endfunction

  function automatic logic [SLOT_W-1:0] exc_rank(input logic [MODE_W-1:0] m);
    return SLOT_W'(m - MODE_W'(MODE_FIQ));
  endfunction

endpackage

// File: rtl/mbrf_slot_map.sv
module mbrf_slot_map
  import mbrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);

  logic              fiq_mode;
  logic              exc_mode;
  logic [SLOT_W-1:0] rank;

  assign fiq_mode = (mode_i == MODE_W'(MODE_FIQ));
  assign exc_mode = is_exc_mode(mode_i);
  assign rank     = exc_rank(mode_i);

  always_comb begin
    slot_o  = '0;
    valid_o = 1'b1;
    if (idx_i < IDX_W'(N_SHARED)) begin
      slot_o = SLOT_W'(idx_i);
    end else if (idx_i <= IDX_W'(FIQ_LAST)) begin
      if (fiq_mode)
        slot_o = SLOT_W'(FIQ_BASE) + SLOT_W'(idx_i - IDX_W'(FIQ_FIRST));
      else
        slot_o = SLOT_W'(idx_i);
    end else if (idx_i <= IDX_W'(LR_IDX)) begin
      if (exc_mode)
        slot_o = SLOT_W'(EXC_BASE) + (rank * SLOT_W'(N_PER_EXC))
               + SLOT_W'(idx_i - IDX_W'(SP_IDX));
      else
        slot_o = SLOT_W'(idx_i);
    end else begin
      valid_o = 1'b0;
    end
  end

endmodule

// File: rtl/mbrf_storage.sv
module mbrf_storage
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_a_slot_i,
  input  logic [SLOT_W-1:0] rd_b_slot_i,
  output logic [DATA_W-1:0] rd_a_q_o,
  output logic [DATA_W-1:0] rd_b_q_o
);

  logic [DATA_W-1:0]  q [N_SLOTS];
  logic [N_SLOTS-1:0] slot_we;

  // next-state: per-slot clock enables
  always_comb begin
    slot_we = '0;
    for (int s = 0; s < N_SLOTS; s++)
      slot_we[s] = wr_en_i && (wr_slot_i == SLOT_W'(s));
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g] <= '0;
      else if (slot_we[g])
        q[g] <= wr_data_i;
    end
  end

  assign rd_a_q_o = (rd_a_slot_i < SLOT_W'(N_SLOTS)) ? q[rd_a_slot_i] : '0;
  assign rd_b_q_o = (rd_b_slot_i < SLOT_W'(N_SLOTS)) ? q[rd_b_slot_i] : '0;

  // R5: an enabled write is held by the addressed slot after the edge
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (q[$past(wr_slot_i)] == $past(wr_data_i)));

  // R5: at most one slot is enabled per cycle
  a_r5_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

endmodule

// File: rtl/mbrf_read_port.sv
module mbrf_read_port
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_valid_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic              wr_live_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] data_o
);

  logic hit;

  assign hit = wr_live_i && (wr_slot_i == rd_slot_i);

  always_comb begin
    if (!rd_valid_i)
      data_o = '0;
    else if (hit)
      data_o = wr_data_i;
    else
      data_o = stored_i;
  end

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int P_RA = 0;
  localparam int P_RB = 1;
  localparam int P_WR = 2;

  logic [IDX_W-1:0]  port_idx   [N_PORTS];
  logic [SLOT_W-1:0] port_slot  [N_PORTS];
  logic              port_valid [N_PORTS];
  logic              wr_live;
  logic [DATA_W-1:0] q_a, q_b;

  assign port_idx[P_RA] = rd_a_idx;
  assign port_idx[P_RB] = rd_b_idx;
  assign port_idx[P_WR] = wr_idx;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    mbrf_slot_map u_map (
      .mode_i  (mode),
      .idx_i   (port_idx[p]),
      .slot_o  (port_slot[p]),
      .valid_o (port_valid[p])
    );
  end

  assign wr_live = wr_en && port_valid[P_WR];

  mbrf_storage #(.DATA_W(DATA_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_live),
    .wr_slot_i   (port_slot[P_WR]),
    .wr_data_i   (wr_data),
    .rd_a_slot_i (port_slot[P_RA]),
    .rd_b_slot_i (port_slot[P_RB]),
    .rd_a_q_o    (q_a),
    .rd_b_q_o    (q_b)
  );

  mbrf_read_port #(.DATA_W(DATA_W)) u_rd_a (
    .rd_valid_i (port_valid[P_RA]),
    .rd_slot_i  (port_slot[P_RA]),
    .stored_i   (q_a),
    .wr_live_i  (wr_live),
    .wr_slot_i  (port_slot[P_WR]),
    .wr_data_i  (wr_data),
    .data_o     (rd_a_data)
  );

  mbrf_read_port #(.DATA_W(DATA_W)) u_rd_b (
    .rd_valid_i (port_valid[P_RB]),
    .rd_slot_i  (port_slot[P_RB]),
    .stored_i   (q_b),
    .wr_live_i  (wr_live),
    .wr_slot_i  (port_slot[P_WR]),
    .wr_data_i  (wr_data),
    .data_o     (rd_b_data)
  );

  // R1: low indices land on the shared slot of the same number
  a_r1_shared_map: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx < 4'd8) |-> (port_slot[P_RA] == SLOT_W'(rd_a_idx)));

  // R2: fast-interrupt banked indices land in the fast-interrupt range
  a_r2_fiq_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && rd_a_idx >= 4'd8 && rd_a_idx <= 4'd12)
    |-> (port_slot[P_RA] >= SLOT_W'(FIQ_BASE) && port_slot[P_RA] < SLOT_W'(EXC_BASE)));

  // R3: every mapped slot exists in the array
  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid[P_WR] |-> (port_slot[P_WR] < SLOT_W'(N_SLOTS)));

  // R7: a read of the slot under write returns the incoming data
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'd15 && rd_b_idx == wr_idx) |-> (rd_b_data == wr_data));

  // R9: index 15 reads as zero on both ports
  a_r9_idx15_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == '0));
  a_r9_idx15_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'd15) |-> (rd_b_data == '0));

endmodule

// File: tb/mode_banked_regfile_bench.sv
`timescale 1ns/1ps
module mode_banked_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mode_banked_regfile #(.DATA_W(32)) u_mode_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // {tag, we, mode, widx, wdata, ridx, expected on port A before the edge}
  localparam int NV = 24;
  localparam logic [91:0] VEC [NV] = '{
    {"R7", 1'b1, 3'd0, 4'd3,  32'h0000A003, 4'd3,  32'h0000A003},
    {"R1", 1'b0, 3'd1, 4'd0,  32'h0,        4'd3,  32'h0000A003},
    {"R7", 1'b1, 3'd0, 4'd8,  32'h0000B008, 4'd8,  32'h0000B008},
    {"R2", 1'b1, 3'd1, 4'd8,  32'h0000F008, 4'd8,  32'h0000F008},
    {"R2", 1'b0, 3'd0, 4'd0,  32'h0,        4'd8,  32'h0000B008},
    {"R2", 1'b0, 3'd2, 4'd0,  32'h0,        4'd8,  32'h0000B008},
    {"R3", 1'b1, 3'd2, 4'd13, 32'h00001013, 4'd13, 32'h00001013},
    {"R3", 1'b1, 3'd3, 4'd13, 32'h00003013, 4'd13, 32'h00003013},
    {"R3", 1'b0, 3'd0, 4'd0,  32'h0,        4'd13, 32'h0},
    {"R3", 1'b0, 3'd2, 4'd0,  32'h0,        4'd13, 32'h00001013},
    {"R3", 1'b1, 3'd0, 4'd13, 32'h00000013, 4'd13, 32'h00000013},
    {"R4", 1'b0, 3'd7, 4'd0,  32'h0,        4'd13, 32'h00000013},
    {"R3", 1'b1, 3'd4, 4'd14, 32'h00004014, 4'd14, 32'h00004014},
    {"R3", 1'b0, 3'd5, 4'd0,  32'h0,        4'd14, 32'h0},
    {"R3", 1'b0, 3'd0, 4'd0,  32'h0,        4'd14, 32'h0},
    {"R4", 1'b1, 3'd6, 4'd12, 32'h0000C012, 4'd12, 32'h0000C012},
    {"R2", 1'b0, 3'd3, 4'd0,  32'h0,        4'd12, 32'h0000C012},
    {"R2", 1'b0, 3'd1, 4'd0,  32'h0,        4'd12, 32'h0},
    {"R9", 1'b1, 3'd0, 4'd15, 32'h0000DEAD, 4'd15, 32'h0},
    {"R9", 1'b0, 3'd0, 4'd0,  32'h0,        4'd0,  32'h0},
    {"R1", 1'b1, 3'd1, 4'd7,  32'h00007777, 4'd7,  32'h00007777},
    {"R1", 1'b0, 3'd5, 4'd0,  32'h0,        4'd7,  32'h00007777},
    {"R3", 1'b1, 3'd1, 4'd14, 32'h0000F014, 4'd14, 32'h0000F014},
    {"R3", 1'b0, 3'd4, 4'd0,  32'h0,        4'd14, 32'h00004014}
  };

  task automatic check(input logic [15:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after a falling edge, sample 1 ns later (well before the rising edge)
  task automatic drive(input logic we, input logic [2:0] m, input logic [3:0] wi,
                       input logic [31:0] wd, input logic [3:0] ra, input logic [3:0] rb);
    @(negedge clk);
    wr_en = we; mode = m; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
    #1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; mode = 3'd0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: everything reads zero after reset
    drive(1'b0, 3'd0, 4'd0, 32'h0, 4'd0, 4'd8);
    check("R8", rd_a_data, 32'h0); check("R8", rd_b_data, 32'h0);
    drive(1'b0, 3'd1, 4'd0, 32'h0, 4'd13, 4'd14);
    check("R8", rd_a_data, 32'h0); check("R8", rd_b_data, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][75], VEC[i][74:72], VEC[i][71:68], VEC[i][67:36], VEC[i][35:32], 4'd15);
      check(VEC[i][91:76], rd_a_data, VEC[i][31:0]);
      check("R9", rd_b_data, 32'h0);
    end

    // R6: two ports at once
    drive(1'b0, 3'd0, 4'd0, 32'h0, 4'd3, 4'd8);
    check("R6", rd_a_data, 32'h0000A003); check("R6", rd_b_data, 32'h0000B008);

    // R7 on port B, then R5 read-back after the edge
    drive(1'b1, 3'd3, 4'd14, 32'h00005514, 4'd14, 4'd14);
    check("R7", rd_b_data, 32'h00005514);
    drive(1'b0, 3'd3, 4'd0, 32'h0, 4'd14, 4'd14);
    check("R5", rd_a_data, 32'h00005514);

    // R5: disabled write changes nothing
    drive(1'b0, 3'd0, 4'd3, 32'hFFFFFFFF, 4'd1, 4'd1);
    drive(1'b0, 3'd0, 4'd0, 32'h0, 4'd3, 4'd0);
    check("R5", rd_a_data, 32'h0000A003);

    // R5: write uses the mode of its own cycle even if mode changes next cycle
    drive(1'b1, 3'd2, 4'd13, 32'h00002213, 4'd0, 4'd0);
    drive(1'b0, 3'd0, 4'd0, 32'h0, 4'd13, 4'd0);
    check("R5", rd_a_data, 32'h00000013);
    drive(1'b0, 3'd2, 4'd0, 32'h0, 4'd13, 4'd0);
    check("R5", rd_a_data, 32'h00002213);

    // R8: reset mid-run clears the array
    @(negedge clk); #1;
    rst_n = 1'b0; mode = 3'd1; rd_a_idx = 4'd3; rd_b_idx = 4'd8; wr_en = 1'b0;
    #1;
    check("R8", rd_a_data, 32'h0); check("R8", rd_b_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule